// File: doc/BRIEF.md
# Power-Up DAC Code Restore Sequencer

This block sits beside the serial command decoder of a trimmer-replacement converter chip. After reset it decides once whether a restore of the stored converter codes is allowed. The restore is allowed only when the write-guard pin and the chip-select pin are both low when the block first samples them after reset. A restore that is allowed does not start at once. It waits for chip-select to go high and then low again.

When the restore starts, the block takes over the read port of the non-volatile array. It fetches the four stored converter codes from addresses 0x100, 0x101, 0x102 and 0x103, one after another, and writes each code into its channel latch. While it runs it raises a hold flag, which keeps the serial decoder from sampling its clock and data pins and from driving its data-out pin. Until a channel has been restored, its latch holds mid-scale.

The restore happens at most once per reset. Once it has finished, the serial interface is free again, and a later write-enable command works as usual.

Top module: `dac_restore_seq`

## Requirements
- R1: Directly after reset every channel code equals 0x80, and `hold_serial`, `restored` and `mem_rd` are low.
- R2: The block is armed only if `guard_n` and `cs_pin` are both low at the first synchronised sample after reset. If it is not armed, no read strobe and no latch load ever happen until the next reset.
- R3: An armed block starts only after `cs_pin` has been seen high and then low. While `cs_pin` stays high, nothing is read and nothing is loaded.
- R4: A restore issues exactly four read strobes. Their `mem_addr` values are 0x100+k for k = 0, 1, 2, 3, in that order.
- R5: `ld_en` is one-hot or zero. Bit k (channel k) pulses once, the pulses come in order k = 0 to 3, and channel k takes the byte returned for address 0x100+k. Channel k occupies bits [8k+7:8k] of `dac_codes`.
- R6: `hold_serial` is high from the first read strobe through the last load. `mem_rd` and `ld_en` are never active while it is low.
- R7: The restore completes within `BUDGET_CYC` clock cycles of hold time, where `BUDGET_CYC` is the clock-cycle equivalent of the 2 ms limit.
- R8: Once `restored` is high it stays high until reset. Further chip-select pulses cause no read strobe and leave every code unchanged.
- R9: A channel that has not yet been loaded in a restore still holds 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| guard_n | input | 1 | Write-guard pin, active low, asynchronous |
| cs_pin | input | 1 | Chip-select pin, asynchronous |
| rd_data | input | 8 | Byte returned by the array RD_LAT cycles after a strobe |
| mem_addr | output | 9 | Array read address |
| mem_rd | output | 1 | Array read strobe, one cycle per fetch |
| ld_en | output | 4 | Per-channel latch load pulse |
| dac_codes | output | 32 | Codes of the four channel latches, channel k at [8k+7:8k] |
| hold_serial | output | 1 | High while the restore runs; the serial decoder ignores its pins |
| restored | output | 1 | High once the restore has completed |

## Verification
On every cycle the embedded assertions check the following:
- strobes and loads occur only under the hold flag;
- addresses and loads follow the ascending channel order;
- untouched channels stay at mid-scale;
- the hold time stays within the budget;
- completion is final.

Whether the block arms at all depends on the pin levels at power-up, and the start needs a high-then-low pattern. Only the bench's sweep over all four power-up pin combinations, with repeated pulses afterwards, can show these. Only the bench can also show that restored codes match the array contents for several data patterns.

// File: rtl/dac_restore_pkg.sv
package dac_restore_pkg;
   typedef enum logic [2:0] {
      RS_WARM   = 3'd0,
      RS_ARMED  = 3'd1,
      RS_CS_HI  = 3'd2,
      RS_FETCH  = 3'd3,
      RS_DONE   = 3'd4,
      RS_BLOCK  = 3'd5
   } rs_state_t;
endpackage

// File: rtl/dac_restore_sync.sv
module dac_restore_sync #(
   parameter int unsigned W = 2,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[gi] <= RST_VAL;
            else        stg[gi] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[gi] <= RST_VAL;
            else        stg[gi] <= stg[gi-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/dac_restore_fsm.sv
module dac_restore_fsm
   import dac_restore_pkg::*;
#(
   parameter int unsigned NCH = 4,
   parameter int unsigned ADDR_W = 9,
   parameter logic [ADDR_W-1:0] BASE = 9'h100,
   parameter int unsigned RD_LAT = 1,
   parameter int unsigned SYNC_N = 2,
   parameter int unsigned BUDGET_CYC = 500000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              guard_s,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic [NCH-1:0]    ld_en,
   output logic              busy,
   output logic              done
);
   localparam int unsigned CH_W = $clog2(NCH);
   localparam int unsigned LW   = $clog2(RD_LAT + 1) + 1;
   localparam int unsigned WW   = $clog2(SYNC_N + 1) + 1;

   rs_state_t         st;
   logic [CH_W-1:0]   ch;
   logic [LW-1:0]     lc;
   logic [WW-1:0]     wcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= RS_WARM;
         ch   <= '0;
         lc   <= '0;
         wcnt <= '0;
      end else begin
         unique case (st)
            RS_WARM:
               if (wcnt == WW'(SYNC_N))
                  st <= (!cs_s && !guard_s) ? RS_ARMED : RS_BLOCK;
               else
                  wcnt <= wcnt + 1'b1;
            RS_ARMED:
               if (cs_s) st <= RS_CS_HI;
            RS_CS_HI:
               if (!cs_s) begin
                  st <= RS_FETCH;
                  ch <= '0;
                  lc <= '0;
               end
            RS_FETCH:
               if (lc == LW'(RD_LAT)) begin
                  lc <= '0;
                  if (ch == CH_W'(NCH - 1)) st <= RS_DONE;
                  else                      ch <= ch + 1'b1;
               end else begin
                  lc <= lc + 1'b1;
               end
            RS_DONE, RS_BLOCK: st <= st;
            default: st <= RS_BLOCK;
         endcase
      end
   end

   always_comb begin
      busy     = (st == RS_FETCH);
      done     = (st == RS_DONE);
      mem_rd   = busy && (lc == '0);
      mem_addr = BASE + ADDR_W'(ch);
      ld_en    = (busy && lc == LW'(RD_LAT)) ? (NCH'(1) << ch) : '0;
   end

   // checker state: expected strobe index and hold-time counter
   logic [CH_W:0] chk_rd;
   logic [31:0]   chk_hold;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_rd   <= '0;
         chk_hold <= '0;
      end else begin
         if (mem_rd) chk_rd <= chk_rd + 1'b1;
         if (busy && chk_hold != '1) chk_hold <= chk_hold + 1'b1;
      end
   end

   assert_rd_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> (mem_addr == BASE + ADDR_W'(chk_rd)) && (chk_rd < (CH_W+1)'(NCH)));
   assert_rd_under_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> busy);
   assert_ld_under_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en != '0) |-> busy);
   assert_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> chk_hold < 32'(BUDGET_CYC));
   assert_done_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);
   assert_no_rd_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_rd && !busy);
endmodule

// File: rtl/dac_restore_latches.sv
module dac_restore_latches #(
   parameter int unsigned NCH = 4,
   parameter int unsigned CW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    ld_en,
   input  logic [CW-1:0]     rd_data,
   output logic [NCH*CW-1:0] codes
);
   localparam logic [CW-1:0] MID = CW'(1) << (CW - 1);
   localparam int unsigned IW = $clog2(NCH) + 1;

   for (genvar gc = 0; gc < NCH; gc++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)        codes[gc*CW +: CW] <= MID;
         else if (ld_en[gc]) codes[gc*CW +: CW] <= rd_data;
   end

   // checker state: number of loads seen so far
   logic [IW-1:0] chk_ld;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)            chk_ld <= '0;
      else if (ld_en != '0)  chk_ld <= chk_ld + 1'b1;

   assert_ld_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ld_en));
   assert_ld_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en != '0) |-> ld_en == (NCH'(1) << chk_ld));

   for (genvar gk = 0; gk < NCH; gk++) begin : g_mid
      assert_mid_until_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (chk_ld <= IW'(gk)) |-> codes[gk*CW +: CW] == MID);
   end
endmodule

// File: rtl/dac_restore_seq.sv
module dac_restore_seq #(
   parameter int unsigned NCH = 4,
   parameter int unsigned CW = 8,
   parameter int unsigned ADDR_W = 9,
   parameter logic [ADDR_W-1:0] BASE = 9'h100,
   parameter int unsigned RD_LAT = 1,
   parameter int unsigned SYNC_N = 2,
   parameter int unsigned BUDGET_CYC = 500000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              guard_n,
   input  logic              cs_pin,
   input  logic [CW-1:0]     rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic [NCH-1:0]    ld_en,
   output logic [NCH*CW-1:0] dac_codes,
   output logic              hold_serial,
   output logic              restored
);
   localparam int unsigned RUN_CYC = NCH * (RD_LAT + 1);

   if (NCH < 2)              begin : g_bad_nch  $error("NCH must be at least 2");        end
   if (CW < 2)               begin : g_bad_cw   $error("CW must be at least 2");         end
   if (RD_LAT < 1)           begin : g_bad_lat  $error("RD_LAT must be at least 1");     end
   if (SYNC_N < 1)           begin : g_bad_sync $error("SYNC_N must be at least 1");     end
   if (RUN_CYC > BUDGET_CYC) begin : g_bad_bud  $error("restore exceeds cycle budget");  end
   if (32'(BASE) + NCH > (32'd1 << ADDR_W)) begin : g_bad_base $error("BASE out of range"); end

   logic [1:0] pins_s;

   dac_restore_sync #(.W(2), .STAGES(SYNC_N), .RST_VAL(2'b11)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_pin, guard_n}),
      .q     (pins_s)
   );

   dac_restore_fsm #(
      .NCH(NCH), .ADDR_W(ADDR_W), .BASE(BASE), .RD_LAT(RD_LAT),
      .SYNC_N(SYNC_N), .BUDGET_CYC(BUDGET_CYC)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_s     (pins_s[1]),
      .guard_s  (pins_s[0]),
      .mem_addr (mem_addr),
      .mem_rd   (mem_rd),
      .ld_en    (ld_en),
      .busy     (hold_serial),
      .done     (restored)
   );

   dac_restore_latches #(.NCH(NCH), .CW(CW)) u_lat (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (ld_en),
      .rd_data (rd_data),
      .codes   (dac_codes)
   );
endmodule

// File: tb/tb_dac_restore_seq.sv
module tb_dac_restore_seq;
   localparam int unsigned NCH = 4;
   localparam int unsigned CW = 8;
   localparam int unsigned BUDGET = 64;

   logic            clk = 0;
   logic            rst_n = 0;
   logic            guard_n = 0;
   logic            cs_pin = 0;
   logic [7:0]      rd_data = 0;
   logic [8:0]      mem_addr;
   logic            mem_rd;
   logic [3:0]      ld_en;
   logic [31:0]     dac_codes;
   logic            hold_serial;
   logic            restored;

   int checks = 0;
   int fails = 0;
   int seed = 0;
   int n_rd = 0;
   int n_ld = 0;
   int hold_cyc = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   dac_restore_seq #(.RD_LAT(1), .SYNC_N(2), .BUDGET_CYC(BUDGET)) dut (
      .clk(clk), .rst_n(rst_n), .guard_n(guard_n), .cs_pin(cs_pin),
      .rd_data(rd_data), .mem_addr(mem_addr), .mem_rd(mem_rd), .ld_en(ld_en),
      .dac_codes(dac_codes), .hold_serial(hold_serial), .restored(restored)
   );

   function automatic logic [7:0] pat(int s, int k);
      return 8'((s * 53 + k * 29 + 7) & 8'hFF);
   endfunction

   // array model, one cycle read latency
   always @(posedge clk)
      if (mem_rd) rd_data <= pat(seed, int'(mem_addr) - 256);

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (mem_rd) begin
            chk(mem_addr == 9'(256 + n_rd), "R4 strobe address", mem_addr, 256 + n_rd);
            chk(hold_serial, "R6 strobe under hold", hold_serial, 1);
            n_rd++;
         end
         if (ld_en != 0) begin
            chk(ld_en == 4'(1 << n_ld), "R5 load order", ld_en, 1 << n_ld);
            chk(hold_serial, "R6 load under hold", hold_serial, 1);
            for (int j = n_ld; j < NCH; j++)
               chk(dac_codes[j*8 +: 8] == 8'h80, "R9 pending channel mid-scale",
                   dac_codes[j*8 +: 8], 8'h80);
            n_ld++;
         end
         if (hold_serial) hold_cyc++;
      end
   end

   task automatic cycles(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic power_up(bit g, bit c);
      rst_n = 0;
      guard_n = g;
      cs_pin = c;
      cycles(3);
      n_rd = 0; n_ld = 0; hold_cyc = 0;
      chk(dac_codes == 32'h80808080, "R1 reset codes", dac_codes, 32'h80808080);
      chk(!hold_serial && !restored && !mem_rd, "R1 reset flags",
          {hold_serial, restored, mem_rd}, 0);
      rst_n = 1;
      cycles(8);
   endtask

   task automatic codes_are(int s, string req);
      for (int k = 0; k < NCH; k++)
         chk(dac_codes[k*8 +: 8] == pat(s, k), req, dac_codes[k*8 +: 8], pat(s, k));
   endtask

   initial begin
      for (int s = 0; s < 4; s++) begin
         for (int combo = 0; combo < 4; combo++) begin
            bit g = combo[0];
            bit c = combo[1];
            bit armed = (g == 0) && (c == 0);
            seed = s * 4 + combo;
            power_up(g, c);
            cs_pin = 1;
            cycles(6);
            chk(n_rd == 0 && n_ld == 0, "R3 nothing while cs high", n_rd + n_ld, 0);
            cs_pin = 0;
            cycles(40);
            if (armed) begin
               chk(n_rd == 4, "R4 strobe count", n_rd, 4);
               chk(n_ld == 4, "R5 load count", n_ld, 4);
               codes_are(seed, "R5 restored codes");
               chk(restored && !hold_serial, "R6 hold released, done", {restored, hold_serial}, 2);
               chk(hold_cyc <= BUDGET, "R7 hold within budget", hold_cyc, BUDGET);
               // later pulses must not restart the restore
               seed = seed + 100;
               cs_pin = 1; cycles(5); cs_pin = 0; cycles(30);
               chk(n_rd == 4, "R8 no new strobes", n_rd, 4);
               chk(restored, "R8 done stays", restored, 1);
               codes_are(seed - 100, "R8 codes unchanged");
            end else begin
               chk(n_rd == 0 && n_ld == 0, "R2 not armed, no restore", n_rd + n_ld, 0);
               chk(dac_codes == 32'h80808080, "R2 codes stay mid-scale", dac_codes, 32'h80808080);
               chk(!restored, "R2 not restored", restored, 0);
            end
         end
      end
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule